// File: doc/BRIEF.md
# Synchronized Local Second Pulse with Phase/Frequency Detector

This block turns a disciplined oscillator clock into a local once-per-second pulse. It also measures how far that pulse sits from an external reference pulse. A counter divides the clock by a modulus taken from an input port. Its count-zero cycle marks the local second.

After reset the counter stands still and the block is armed. The first reference rise restarts the counter at zero, and from then on the counter runs freely. Later reference rises do not touch the counter unless the block is re-armed through a control input.

A three-state phase/frequency detector compares the reference event with the local count-zero event. It holds `up_o` high while the reference leads and `dn_o` high while the local pulse leads. Each interval is one cycle wide per clock of separation. When an interval closes, the block presents the separation as a signed count with a one-cycle strobe, so that a downstream loop filter can take it. A separation larger than half the modulus is flagged as a cycle slip.

Top module: `pps_sync_pfd`

## Requirements
- R1: After reset the divider is stopped. `loc_pps_o`, `up_o`, `dn_o`, `diff_vld_o` and `slip_o` are low, and the block is armed for a resync.
- R2: A reference rise is the input sampled high at clock edge k after being sampled low at edge k-1. If the block is armed, this rise restarts the divider: its count is zero in the cycle after edge k+1, and `loc_pps_o` is high in that cycle. The same edge clears the armed state. At edge k+2 the block strobes a difference of 0.
- R3: Once started, the divider counts 0 to `modulus_i`-1 and wraps. `loc_pps_o` is high for the first `HIGH_CYC` counts of every period. A reference rise that arrives while the block is not armed leaves the phase unchanged.
- R4: A reference rise sampled at edge r arrives in the cycle after edge r+1. If it leads the local count-zero cycle by d cycles, `up_o` is high for exactly d cycles, starting in the cycle after the reference arrives. If the local event leads by d, `dn_o` is high for exactly d cycles, starting in the cycle after the local event. `up_o` and `dn_o` are never high together.
- R5: `diff_vld_o` is high for one cycle, directly after the last `up_o` or `dn_o` cycle. While it is high, `diff_o` carries +d when the reference led and -d when the local pulse led. It carries 0, with no `up_o` or `dn_o` cycle, when both events fall in the same cycle. `diff_o` holds its value between strobes.
- R6: `arm_i` high at a clock edge re-arms the block. The next reference rise realigns the divider as in R2 and drops any open interval without a strobe.
- R7: `slip_o` is high together with `diff_vld_o` when |d| is greater than floor(`modulus_i`/2), and low at all other times.
- R8: A reference input held high for several cycles counts as a single rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pps_i | input | 1 | External reference pulse, synchronous to clk |
| arm_i | input | 1 | Re-arm request; the next reference rise realigns the divider |
| modulus_i | input | CNT_W | Divider modulus in clock cycles, at least 2 |
| loc_pps_o | output | 1 | Local once-per-period pulse |
| up_o | output | 1 | High while the reference leads the local event |
| dn_o | output | 1 | High while the local event leads the reference |
| diff_o | output | CNT_W+1 | Signed separation in cycles, positive when the reference leads |
| diff_vld_o | output | 1 | One-cycle strobe for a new `diff_o` |
| slip_o | output | 1 | Cycle-slip flag, valid with the strobe |

## Verification
Two events can fall in the same cycle and must not disturb each other. The first case is a reference event landing in the local count-zero cycle. The sweep places the second reference of each trial at every offset from well before to well after the local event, including offset zero. At offset zero the only correct response is a strobe with difference 0 and no `up_o` or `dn_o` cycle.

The second case is a resync landing while a local-led interval is still open from the previous trial. The resync must close that interval silently and then produce exactly one zero strobe. Every cycle of every trial is compared against arithmetic expectations, for one even and one odd modulus, so the slip threshold is tested on both sides of its floor division.

// File: rtl/pps_sync_pfd.sv
module pps_sync_pfd #(
  parameter int CNT_W    = 24,
  parameter int HIGH_CYC = 1_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_pps_i,
  input  logic                    arm_i,
  input  logic [CNT_W-1:0]        modulus_i,
  output logic                    loc_pps_o,
  output logic                    up_o,
  output logic                    dn_o,
  output logic signed [CNT_W:0]   diff_o,
  output logic                    diff_vld_o,
  output logic                    slip_o
);

  localparam logic [CNT_W-1:0] HIGH_W = CNT_W'(HIGH_CYC);
  localparam logic [CNT_W-1:0] IV_MAX = '1;

  typedef enum logic [1:0] {PD_IDLE, PD_UP, PD_DN} pd_t;

  logic             ref_q1, ref_q2, ref_d;
  logic             armed, running;
  logic [CNT_W-1:0] cnt, iv;
  pd_t              pd;

  wire ref_tick = ref_q1 & ~ref_q2;
  wire resync   = armed & ref_tick;
  wire loc_tick = running & (cnt == '0);
  wire ref_ev   = running & ref_d;
  wire wrap     = cnt >= modulus_i - 1'b1;
  wire [CNT_W-1:0] half   = modulus_i >> 1;
  wire [CNT_W-1:0] iv_inc = (iv == IV_MAX) ? iv : iv + 1'b1;

  assign loc_pps_o = running && (cnt < HIGH_W);
  assign up_o      = (pd == PD_UP);
  assign dn_o      = (pd == PD_DN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q1     <= 1'b0;
      ref_q2     <= 1'b0;
      ref_d      <= 1'b0;
      armed      <= 1'b1;
      running    <= 1'b0;
      cnt        <= '0;
      iv         <= '0;
      pd         <= PD_IDLE;
      diff_o     <= '0;
      diff_vld_o <= 1'b0;
      slip_o     <= 1'b0;
    end else begin
      ref_q1 <= ref_pps_i;
      ref_q2 <= ref_q1;
      ref_d  <= ref_tick;

      if (arm_i)       armed <= 1'b1;
      else if (resync) armed <= 1'b0;

      if (resync) begin
        cnt     <= '0;
        running <= 1'b1;
      end else if (running) begin
        cnt <= wrap ? '0 : cnt + 1'b1;
      end

      diff_vld_o <= 1'b0;
      slip_o     <= 1'b0;
      if (resync) begin
        pd <= PD_IDLE;
      end else begin
        case (pd)
          PD_IDLE: begin
            if (ref_ev && loc_tick) begin
              diff_o     <= '0;
              diff_vld_o <= 1'b1;
            end else if (ref_ev) begin
              pd <= PD_UP;
              iv <= CNT_W'(1);
            end else if (loc_tick) begin
              pd <= PD_DN;
              iv <= CNT_W'(1);
            end
          end
          PD_UP: begin
            if (loc_tick) begin
              pd         <= PD_IDLE;
              diff_o     <= $signed({1'b0, iv});
              diff_vld_o <= 1'b1;
              slip_o     <= iv > half;
            end else begin
              iv <= iv_inc;
            end
          end
          PD_DN: begin
            if (ref_ev) begin
              pd         <= PD_IDLE;
              diff_o     <= -$signed({1'b0, iv});
              diff_vld_o <= 1'b1;
              slip_o     <= iv > half;
            end else begin
              iv <= iv_inc;
            end
          end
          default: pd <= PD_IDLE;
        endcase
      end
    end
  end

  a_r1_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!loc_pps_o && !up_o && !dn_o && !diff_vld_o));

  a_r2_resync_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && !arm_i) |=> (loc_pps_o && !armed && !up_o && !dn_o));

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt < modulus_i && !resync) |=> ($stable(modulus_i) -> cnt < modulus_i));

  a_r5_up_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(up_o) && !$past(resync)) |-> (diff_vld_o && diff_o > 0));

  a_r5_dn_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dn_o) && !$past(resync)) |-> (diff_vld_o && diff_o < 0));

  a_r7_slip_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |-> diff_vld_o);

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    diff_vld_o |=> !diff_vld_o);

endmodule

// File: tb/sim_pps_sync_pfd.sv
`timescale 1ns/1ps
module sim_pps_sync_pfd;
  localparam int CW = 8;
  localparam int HC = 3;

  logic clk = 1'b0, rst_n = 1'b0, ref_i = 1'b0, arm = 1'b0;
  logic [CW-1:0] mod_i = CW'(16);
  logic loc_pps, up, dn, vld, slip;
  logic signed [CW:0] diff;

  pps_sync_pfd #(.CNT_W(CW), .HIGH_CYC(HC)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_pps_i(ref_i), .arm_i(arm), .modulus_i(mod_i),
    .loc_pps_o(loc_pps), .up_o(up), .dn_o(dn), .diff_o(diff),
    .diff_vld_o(vld), .slip_o(slip));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit ended = 1'b0;

  task automatic chk(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got=%0d exp=%0d", req, cyc, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wait_cyc(int n);
    @(negedge clk);
    while (cyc < n) @(negedge clk);
  endtask

  // One trial: re-arm (R6), resync with a held reference (R2, R8), then one
  // unarmed reference at offset off from the next local zero cycle (R3-R5, R7).
  task automatic trial(int m, int off);
    int k, l0, l1, a, r, vn, endc;
    @(negedge clk);
    mod_i = CW'(m);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
    ref_i = 1'b1;
    k = cyc + 1;
    @(negedge clk);
    @(negedge clk);
    ref_i = 1'b0;
    l0   = k + 1;
    l1   = l0 + m;
    a    = l1 + off;
    r    = a - 1;
    vn   = ((a > l1) ? a : l1) + 1;
    endc = l1 + m;
    fork
      begin
        wait_cyc(r - 1);
        ref_i = 1'b1;
        wait_cyc(r + 2);
        ref_i = 1'b0;
      end
      begin
        for (int n = k + 1; n <= endc; n++) begin
          bit e_loc, e_up, e_dn, e_v;
          int e_d;
          if (n > k + 1) @(negedge clk);
          e_loc = ((n - l0) % m) < HC;
          e_up  = (off < 0) && (n > a) && (n <= l1);
          e_dn  = (off > 0) && (n > l1) && (n <= a);
          e_v   = (n == k + 2) || (n == vn);
          chk(loc_pps == e_loc, "R3 loc_pps", int'(loc_pps), int'(e_loc));
          chk(up == e_up, "R4 up", int'(up), int'(e_up));
          chk(dn == e_dn, "R4 dn", int'(dn), int'(e_dn));
          chk(vld == e_v, "R5 strobe", int'(vld), int'(e_v));
          if (n == k + 2) begin
            chk(int'(diff) == 0, "R2 zero after resync", int'(diff), 0);
            chk(slip == 1'b0, "R7 no slip after resync", int'(slip), 0);
          end else if (n == vn) begin
            e_d = -off;
            chk(int'(diff) == e_d, "R5 diff", int'(diff), e_d);
            chk(slip == ((off < 0 ? -off : off) > m / 2), "R7 slip",
                int'(slip), int'((off < 0 ? -off : off) > m / 2));
          end else begin
            chk(slip == 1'b0, "R7 slip idle", int'(slip), 0);
          end
        end
      end
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(!loc_pps && !up && !dn && !vld && !slip, "R1 reset quiet",
          int'({loc_pps, up, dn, vld, slip}), 0);
    end
    for (int off = -13; off <= 14; off++) trial(16, off);
    for (int off = -8; off <= 9; off++) trial(11, off);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): got=%0d exp=%0d", cyc, 0);
    finish_up();
  end
endmodule